// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt events from eight sources on behalf of a small 8-bit accumulator-style processor. It decides when to interrupt that processor and which service routine address to hand over. Each source owns a pending flag, an enable bit and a level bit that chooses one of two priorities. A global enable sits above all of them. Pending flags capture events whether or not anything is enabled. The processor sees a request only when the flag, the source enable and the effective global enable all agree, and only at an instruction boundary.

When the processor accepts the request through the acknowledge strobe, the controller records the level as in service. It then keeps a lower or equal level from nesting on top of that level until the processor signals a return. Two timing details of the target core are reproduced. A return lets exactly one instruction run before any new request can be raised. A software clear of the global enable still lets one request through at the next boundary, if the instruction after that boundary takes one cycle. Per-source auto-clear on acknowledge is chosen at build time.

Top module: `intc_two_level`

## Requirements
- R1: After synchronous reset, `irq_req` is 0, and all pending, enable, priority and global-enable bits read back as 0.
- R2: A `src_set` pulse sets that source's pending flag whatever the enables are. If `src_set` and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R3: Register map on `wr_addr`/`rd_addr`: address 0 holds the global enable in bit 7, and its other bits read 0. Address 1 is the per-source enable mask, with bit i for source i. Address 2 is the level mask, where 1 means high priority. Address 3 is the pending flags: a write loads the written value, so 1 sets a flag and 0 clears it. `rd_data` returns the state of the addressed register one clock after the address is presented.
- R4: A request is raised only in a cycle with `insn_done` = 1, and only when some source has its pending flag and enable bit at 1 and the effective global enable is 1. A pending flag set by software requests exactly like a hardware event. `irq_req` rises on the clock edge that samples that boundary.
- R5: Any eligible high-priority source wins over any low-priority one. Within one level, the lowest source index wins.
- R6: `irq_vec` equals 0x0003 + 8 × (winning index). It stays stable, together with `irq_req` = 1, until `vec_ack` is sampled high, whatever happens on other inputs in the meantime.
- R7: On the edge that samples `vec_ack` while `irq_req` = 1, `irq_req` falls and the winning level is marked in service. The winning pending flag clears only if that source's bit in `AUTO_CLEAR` is 1; otherwise the flag stays set.
- R8: A high-priority request is raised while only low level is in service. A low-priority request is never raised while any level is in service. A high-priority request is never raised while high level is in service.
- R9: A `reti` strobe clears the high in-service mark if it is set, and otherwise clears the low mark. It leaves the pending flags unchanged. The first `insn_done` after `reti` never raises a request; the second one can.
- R10: After a write that clears the global enable, the enable reads back 0 at once. The next boundary still raises a request if `insn_multi` = 0 in that cycle, and raises none if `insn_multi` = 1. Every later boundary is masked until the enable is written to 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 8 | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| insn_done | input | 1 | Instruction boundary strobe |
| insn_multi | input | 1 | With `insn_done`: the next instruction takes more than one cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_ack | input | 1 | Processor accepts the current vector |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 16 | Service routine address for the current request |

## Verification
The bench builds the controller with `AUTO_CLEAR` = 8'h05, so sources 0 and 2 clear on acknowledge and all others stay pending. The same run therefore covers both flag behaviours, and a flag left set after a return comes back on the second boundary. The level mask is rewritten during the run so that a high-priority source at index 2 competes with a lower-index low-priority source. With default vector base 0x0003 and step 8, the expected addresses 3, 11, 19, 27, 35 and 43 can each be told apart.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_ENAB = 2'd1,
    RA_PRIO = 2'd2,
    RA_PEND = 2'd3
  } reg_addr_e;

  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
  localparam int unsigned NUM_LVL = 2;

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DW = 8,
  parameter logic [NUM_SRC-1:0] AUTO_CLEAR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_addr,
  input  logic               insn_done,
  input  logic [NUM_SRC-1:0] ack_sel,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] enab,
  output logic [NUM_SRC-1:0] prio,
  output logic               ea,
  output logic               grace,
  output logic [DW-1:0]      rd_data
);

  localparam int unsigned EA_BIT = DW - 1;

  logic [NUM_SRC-1:0] pend_q, pend_n, enab_q, prio_q;
  logic               ea_q, grace_q;
  logic [DW-1:0]      rd_q;
  logic               wr_ctrl, wr_enab, wr_prio, wr_pend;

  assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
  assign wr_enab = wr_en && (reg_addr_e'(wr_addr) == RA_ENAB);
  assign wr_prio = wr_en && (reg_addr_e'(wr_addr) == RA_PRIO);
  assign wr_pend = wr_en && (reg_addr_e'(wr_addr) == RA_PEND);

  // Per-source next pending value: hardware event beats software load,
  // software load beats the build-time auto-clear on acknowledge.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    logic hw_clr;
    assign hw_clr    = ack_sel[i] & AUTO_CLEAR[i];
    assign pend_n[i] = src_set[i] | (wr_pend ? wr_data[i] : (pend_q[i] & ~hw_clr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      enab_q  <= '0;
      prio_q  <= '0;
      ea_q    <= 1'b0;
      grace_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (wr_enab) enab_q <= wr_data[NUM_SRC-1:0];
      if (wr_prio) prio_q <= wr_data[NUM_SRC-1:0];
      if (wr_ctrl) begin
        ea_q    <= wr_data[EA_BIT];
        grace_q <= ea_q & ~wr_data[EA_BIT];
      end else if (insn_done) begin
        grace_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (reg_addr_e'(rd_addr))
        RA_CTRL: rd_q <= {ea_q, {(DW-1){1'b0}}};
        RA_ENAB: rd_q <= DW'(enab_q);
        RA_PRIO: rd_q <= DW'(prio_q);
        RA_PEND: rd_q <= DW'(pend_q);
        default: rd_q <= '0;
      endcase
    end
  end

  assign pend    = pend_q;
  assign enab    = enab_q;
  assign prio    = prio_q;
  assign ea      = ea_q;
  assign grace   = grace_q;
  assign rd_data = rd_q;

  // R2
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));

  // R10
  grace_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grace_q) |-> ($past(ea_q) && !ea_q));

endmodule

// File: rtl/intc_ffs.sv
module intc_ffs #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDXW = 3
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] enab,
  input  logic [NUM_SRC-1:0] prio,
  output logic               hi_any,
  output logic [IDXW-1:0]    hi_idx,
  output logic               lo_any,
  output logic [IDXW-1:0]    lo_idx
);

  logic [NUM_SRC-1:0] cand;
  logic [NUM_LVL-1:0] lvl_any;
  logic [IDXW-1:0]    lvl_idx [NUM_LVL];

  assign cand = pend & enab;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] lvl_mask;
    assign lvl_mask = (l == LVL_HI) ? (cand & prio) : (cand & ~prio);
    intc_ffs #(.W(NUM_SRC), .IW(IDXW)) u_ffs (
      .vec (lvl_mask),
      .any (lvl_any[l]),
      .idx (lvl_idx[l])
    );
  end

  assign hi_any = lvl_any[LVL_HI];
  assign hi_idx = lvl_idx[LVL_HI];
  assign lo_any = lvl_any[LVL_LO];
  assign lo_idx = lvl_idx[LVL_LO];

endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDXW = 3,
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h3,
  parameter logic [AW-1:0] VEC_STEP = 'h8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_done,
  input  logic               insn_multi,
  input  logic               reti,
  input  logic               vec_ack,
  input  logic               ea,
  input  logic               grace,
  input  logic               hi_any,
  input  logic [IDXW-1:0]    hi_idx,
  input  logic               lo_any,
  input  logic [IDXW-1:0]    lo_idx,
  output logic               irq_req,
  output logic [AW-1:0]      irq_vec,
  output logic [NUM_SRC-1:0] ack_sel
);

  logic               req_q, lvl_q, hold_q;
  logic [NUM_LVL-1:0] isv_q, isv_n;
  logic [IDXW-1:0]    src_q, pick;
  logic [AW-1:0]      vec_q;
  logic               ea_eff, eval, take_hi, take_lo, acked;

  // Late global-enable clear: honoured one boundary late for a 1-cycle successor.
  assign ea_eff  = ea | (grace & ~insn_multi);
  assign eval    = insn_done & ~req_q & ~hold_q & ~reti & ea_eff;
  assign take_hi = eval & hi_any & ~isv_q[LVL_HI];
  assign take_lo = eval & lo_any & (isv_q == '0) & ~take_hi;
  assign pick    = take_hi ? hi_idx : lo_idx;
  assign acked   = req_q & vec_ack;

  always_comb begin
    isv_n = isv_q;
    if (reti) begin
      if (isv_n[LVL_HI]) isv_n[LVL_HI] = 1'b0;
      else               isv_n[LVL_LO] = 1'b0;
    end
    if (acked) isv_n[lvl_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      lvl_q  <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
      hold_q <= 1'b0;
      isv_q  <= '0;
    end else begin
      isv_q <= isv_n;
      if (reti)           hold_q <= 1'b1;
      else if (insn_done) hold_q <= 1'b0;
      if (acked) begin
        req_q <= 1'b0;
      end else if (take_hi | take_lo) begin
        req_q <= 1'b1;
        lvl_q <= take_hi;
        src_q <= pick;
        vec_q <= VEC_BASE + VEC_STEP * AW'(pick);
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ack_sel[i] = acked && (src_q == IDXW'(i));
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && !vec_ack) |=> (req_q && $stable(vec_q)));

  // R4
  req_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(insn_done));

  // R8
  low_no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_q) && !lvl_q) |-> ($past(isv_q) == '0));

  // R7
  ack_marks_level_chk: assert property (@(posedge clk) disable iff (rst)
    acked |=> (!req_q && isv_q[$past(lvl_q)]));

  // R9
  reti_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !acked && isv_q[LVL_HI]) |=> (!isv_q[LVL_HI] && (isv_q[LVL_LO] == $past(isv_q[LVL_LO]))));

endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h3,
  parameter logic [AW-1:0] VEC_STEP = 'h8,
  parameter logic [NUM_SRC-1:0] AUTO_CLEAR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               insn_done,
  input  logic               insn_multi,
  input  logic               reti,
  input  logic               vec_ack,
  output logic               irq_req,
  output logic [AW-1:0]      irq_vec
);

  localparam int unsigned IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend, enab, prio, ack_sel;
  logic               ea, grace, hi_any, lo_any;
  logic [IDXW-1:0]    hi_idx, lo_idx;

  intc_regs #(
    .NUM_SRC    (NUM_SRC),
    .DW         (DW),
    .AUTO_CLEAR (AUTO_CLEAR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .src_set   (src_set),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .insn_done (insn_done),
    .ack_sel   (ack_sel),
    .pend      (pend),
    .enab      (enab),
    .prio      (prio),
    .ea        (ea),
    .grace     (grace),
    .rd_data   (rd_data)
  );

  intc_arbiter #(
    .NUM_SRC (NUM_SRC),
    .IDXW    (IDXW)
  ) u_arb (
    .pend   (pend),
    .enab   (enab),
    .prio   (prio),
    .hi_any (hi_any),
    .hi_idx (hi_idx),
    .lo_any (lo_any),
    .lo_idx (lo_idx)
  );

  intc_seq #(
    .NUM_SRC  (NUM_SRC),
    .IDXW     (IDXW),
    .AW       (AW),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .insn_multi (insn_multi),
    .reti       (reti),
    .vec_ack    (vec_ack),
    .ea         (ea),
    .grace      (grace),
    .hi_any     (hi_any),
    .hi_idx     (hi_idx),
    .lo_any     (lo_any),
    .lo_idx     (lo_idx),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .ack_sel    (ack_sel)
  );

endmodule

// File: tb/tb_intc_two_level.sv
module tb_intc_two_level;

  localparam int N = 8;
  localparam logic [7:0] AUTO = 8'h05;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_set = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       insn_done = 1'b0, insn_multi = 1'b0, reti = 1'b0, vec_ack = 1'b0;
  logic       irq_req;
  logic [15:0] irq_vec;

  intc_two_level #(.AUTO_CLEAR(AUTO)) dut (
    .clk(clk), .rst(rst), .src_set(src_set), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .insn_done(insn_done),
    .insn_multi(insn_multi), .reti(reti), .vec_ack(vec_ack), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference state
  bit [7:0] m_pend, m_en, m_pri, m_rd;
  bit       m_ea, m_grace, m_hold, m_req;
  bit [1:0] m_isv;
  int       m_src, m_lvl, m_vec;

  always @(posedge clk) begin : model
    bit [7:0] n_pend;
    bit [1:0] n_isv;
    bit       n_req, n_hold, n_ea, n_grace;
    int       n_src, n_lvl, n_vec, pick, plv;
    if (rst) begin
      m_pend = 0; m_en = 0; m_pri = 0; m_rd = 0; m_ea = 0; m_grace = 0;
      m_hold = 0; m_req = 0; m_isv = 0; m_src = 0; m_lvl = 0; m_vec = 0;
    end else begin
      n_pend = m_pend; n_isv = m_isv; n_req = m_req; n_hold = m_hold;
      n_ea = m_ea; n_grace = m_grace; n_src = m_src; n_lvl = m_lvl; n_vec = m_vec;
      pick = -1; plv = 0;
      if (!m_req && insn_done && !m_hold && !reti && (m_ea || (m_grace && !insn_multi))) begin
        for (int i = 0; i < N; i++)
          if (pick < 0 && m_pend[i] && m_en[i] && m_pri[i] && !m_isv[1]) begin pick = i; plv = 1; end
        if (pick < 0 && m_isv == 0)
          for (int i = 0; i < N; i++)
            if (pick < 0 && m_pend[i] && m_en[i] && !m_pri[i]) pick = i;
        if (pick >= 0) begin n_req = 1; n_src = pick; n_lvl = plv; n_vec = 3 + 8 * pick; end
      end
      if (reti) begin
        if (n_isv[1]) n_isv[1] = 0; else n_isv[0] = 0;
      end
      if (m_req && vec_ack) begin
        n_req = 0;
        n_isv[m_lvl] = 1;
        if (AUTO[m_src]) n_pend[m_src] = 0;
      end
      if (wr_en && wr_addr == 3) n_pend = wr_data;
      n_pend = n_pend | src_set;
      if (wr_en && wr_addr == 1) m_en = wr_data;
      if (wr_en && wr_addr == 2) m_pri = wr_data;
      if (wr_en && wr_addr == 0) begin n_ea = wr_data[7]; n_grace = m_ea && !wr_data[7]; end
      else if (insn_done) n_grace = 0;
      if (reti) n_hold = 1; else if (insn_done) n_hold = 0;
      case (rd_addr)
        2'd0: m_rd = {m_ea, 7'b0};
        2'd1: m_rd = m_en;
        2'd2: m_rd = m_pri;
        default: m_rd = m_pend;
      endcase
      m_pend = n_pend; m_isv = n_isv; m_req = n_req; m_hold = n_hold;
      m_ea = n_ea; m_grace = n_grace; m_src = n_src; m_lvl = n_lvl; m_vec = n_vec;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One clock: compare against the model at the falling edge, then release strobes.
  task automatic cyc();
    @(negedge clk);
    n_chk++;
    if (irq_req !== m_req || (m_req && irq_vec !== 16'(m_vec)) || rd_data !== m_rd) begin
      n_fail++;
      $display("FAIL R4/R6 per-cycle model: req %0b vec %0d rd %02h, expected req %0b vec %0d rd %02h",
               irq_req, irq_vec, rd_data, m_req, m_vec, m_rd);
    end
    src_set = '0; wr_en = 0; insn_done = 0; insn_multi = 0; reti = 0; vec_ack = 0;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc();
  endtask

  task automatic boundary(bit multi);
    insn_done = 1; insn_multi = multi; cyc();
  endtask

  task automatic ack();
    vec_ack = 1; cyc();
  endtask

  task automatic ret();
    reti = 1; cyc();
  endtask

  task automatic rdchk(logic [1:0] a, logic [7:0] exp, string tag);
    rd_addr = a; cyc();
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic reqchk(bit exp_req, int exp_vec, string tag);
    chk(irq_req === exp_req, tag, irq_req, exp_req);
    if (exp_req) chk(irq_vec === 16'(exp_vec), tag, irq_vec, exp_vec);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R1 reset state
    rdchk(2'd0, 8'h00, "R1 ctrl after reset");
    rdchk(2'd3, 8'h00, "R1 pending after reset");
    reqchk(0, 0, "R1 no request after reset");

    // R2 latch while disabled
    src_set = 8'h08; cyc();
    rdchk(2'd3, 8'h08, "R2 flag latched with enables off");

    // R3 register map
    wreg(2'd1, 8'hFF);
    wreg(2'd2, 8'h10);
    wreg(2'd0, 8'h80);
    rdchk(2'd0, 8'h80, "R3 global enable bit 7");
    rdchk(2'd2, 8'h10, "R3 level mask");
    rdchk(2'd1, 8'hFF, "R3 enable mask");

    // R4 request at boundary, R6 vector and hold
    reqchk(0, 0, "R4 no request before boundary");
    boundary(0);
    reqchk(1, 27, "R4 request for source 3");
    boundary(0);
    src_set = 8'h10; cyc();
    reqchk(1, 27, "R6 vector held until ack");
    ack();
    reqchk(0, 0, "R7 request drops on ack");
    rdchk(2'd3, 8'h18, "R7 source 3 keeps flag");

    // R8 nesting rules (source 4 high, pending since above)
    wreg(2'd3, 8'h02);
    boundary(0);
    reqchk(0, 0, "R8 low does not nest on low");
    src_set = 8'h10; cyc();
    boundary(0);
    reqchk(1, 35, "R8 high preempts low service");
    ack();
    src_set = 8'h10; cyc();
    boundary(0);
    reqchk(0, 0, "R8 high does not nest on high");

    // R2 hardware set beats software clear
    wr_en = 1; wr_addr = 2'd3; wr_data = 8'h00; src_set = 8'h20; cyc();
    rdchk(2'd3, 8'h20, "R2 event wins over cleared write");

    // R9 return handling
    ret();
    boundary(0);
    boundary(0);
    reqchk(0, 0, "R9 low still in service after first return");
    ret();
    rdchk(2'd3, 8'h20, "R9 return leaves pending");
    boundary(0);
    reqchk(0, 0, "R9 first boundary after return ignored");
    boundary(0);
    reqchk(1, 43, "R9 re-request on second boundary");
    ack();
    ret();

    // R5 arbitration with auto-clear (R7)
    wreg(2'd3, 8'h00);
    wreg(2'd2, 8'h04);
    wreg(2'd3, 8'h05);
    boundary(0);
    boundary(0);
    reqchk(1, 19, "R5 high source 2 beats low source 0");
    ack();
    rdchk(2'd3, 8'h01, "R7 source 2 auto-cleared");
    ret();
    boundary(0);
    boundary(0);
    reqchk(1, 3, "R5 low source 0 after high serviced");
    ack();
    rdchk(2'd3, 8'h00, "R7 source 0 auto-cleared");
    ret();
    boundary(0);

    // R10 late global-enable clear, single-cycle successor
    wreg(2'd3, 8'h02);
    wreg(2'd0, 8'h00);
    rdchk(2'd0, 8'h00, "R10 enable reads 0 at once");
    boundary(0);
    reqchk(1, 11, "R10 one request slips through");
    ack();
    ret();
    boundary(0);
    boundary(0);
    boundary(0);
    reqchk(0, 0, "R10 later boundaries masked");

    // R10 multi-cycle successor blocks
    wreg(2'd0, 8'h80);
    boundary(0);
    reqchk(1, 11, "R4 pending left set requests again");
    ack();
    ret();
    boundary(0);
    wreg(2'd0, 8'h00);
    boundary(1);
    reqchk(0, 0, "R10 multi-cycle successor blocks");
    boundary(0);
    reqchk(0, 0, "R10 still masked");

    // R4 individual enable masks
    wreg(2'd0, 8'h80);
    wreg(2'd1, 8'hFD);
    boundary(0);
    boundary(0);
    reqchk(0, 0, "R4 disabled source ignored");
    rdchk(2'd3, 8'h02, "R4 disabled flag still pending");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule